// File: doc/BRIEF.md
# Four-Counter Event Performance Monitor

This block counts micro-architectural events for a processor core. The core presents a vector of single-cycle event pulses, one line per 8-bit event code. Each of four event counters picks one code through its own 8-bit field of a shared selection register. It adds one for every pulse on that line while the unit is running. A free-running cycle counter advances on every clock while the unit is running.

Software reaches all state through a register port. A group bit selects between the system registers (group 0) and the counter bank (group 1), and a 4-bit index picks the register inside the group. A write takes effect at the next clock edge. Read data is combinational from the current state.

When an event counter rolls over from all ones to zero, it latches a sticky overflow flag. The interrupt request is raised whenever a latched flag has its enable bit set. A single run bit starts and stops every counter together. The select code 0xff parks a counter in a low-power, non-counting state, and this is the reset value of every field.

Top module: `perf_monitor_unit`

## Requirements
- R1: After reset the run bit is 0, every counter and the cycle counter read 0, the interrupt-enable and overflow-flag registers read 0, the selection register reads 0xFFFFFFFF and `irq` is low.
- R2: Counter n takes its event code from bits 8n+7..8n of the selection register (group 0, index 8). Counter 0 uses bits 7..0 and counter 3 uses bits 31..24.
- R3: While running, a counter adds exactly one at the clock edge where its selected event line is high.
- R4: A counter whose select field holds 0xff never increments, whatever the event lines do.
- R5: The countable codes are 0x00 to 0x1c, 0x1e, 0x20, 0x23, 0x40, 0x41 and 0x48. A counter selecting any other code stays unchanged when its line pulses.
- R6: While the run bit (bit 0 of group 0, index 0) is clear, neither the event counters nor the cycle counter change except by register writes.
- R7: The cycle counter (group 0, index 1) is readable and writable, adds one on every clock edge while running, and wraps from all ones to zero.
- R8: Event counters 0 to 3 are read and written at group 1, indices 0 to 3.
- R9: A counter that wraps from all ones to zero sets its bit in the overflow-flag register (group 0, index 5; bit n for counter n). Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some counter has both its overflow flag and its interrupt-enable bit (group 0, index 4; bit n for counter n) set.
- R11: A register write to a counter at the same edge as a counted event loads the written value, skips the increment and sets no overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_lines | input | 256 | Event pulses, bit k is event code k |
| reg_wr | input | 1 | Register write strobe |
| reg_grp | input | 1 | 0 = system registers, 1 = counter bank |
| reg_idx | input | 4 | Register index within the group |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the unit with 8-bit event counters and an 8-bit cycle counter, keeping four counters and the full 8-bit code space. With these sizes, rollover, flag latching and cycle-counter wrap take only a few hundred clocks. All 256 select codes can therefore be swept on one counter, each compared with the countable list computed in the bench. Field placement, parking, the run gate, flag clearing, interrupt gating and the same-edge write/event collision are each driven as directed patterns on top of that.

// File: rtl/pmu_pkg.sv
// Package: shared constants, register index map and the countable-code rule
// for the performance monitor. Assumes 8-bit event codes.
package pmu_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 8;
    localparam int NUM_LINES = 1 << CODE_W;
    localparam logic [CODE_W-1:0] PARK_CODE = 8'hff;

    // System register indices (group 0)
    typedef enum logic [3:0] {
        SYS_CTRL  = 4'd0,
        SYS_CYCLE = 4'd1,
        SYS_IEN   = 4'd4,
        SYS_FLAG  = 4'd5,
        SYS_SEL   = 4'd8
    } sys_idx_e;

    // True when an event code is one the core can raise
    function automatic logic code_is_countable(input logic [CODE_W-1:0] code);
        return (code <= 8'h1c) || (code == 8'h1e) || (code == 8'h20) ||
               (code == 8'h23) || (code == 8'h40) || (code == 8'h41) ||
               (code == 8'h48);
    endfunction

endpackage

// File: rtl/pmu_event_select.sv
// Module: picks one event line by code and qualifies it.
// Assumes the line vector spans the full code space. A parked (0xff) or
// non-countable code never produces a hit. The hit is gated by the run bit.
module pmu_event_select
    import pmu_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic [CODE_W-1:0] sel,
    input  logic [LINES-1:0]  ev_lines,
    input  logic              run,
    output logic              hit
);

    // Purpose: combine the run gate, the park check, the code rule and the line
    always_comb begin
        hit = run && (sel != PARK_CODE) && code_is_countable(sel) && ev_lines[sel];
    end

endmodule

// File: rtl/pmu_counter.sv
// Module: loadable up-counter shared by event and cycle counting.
// Assumes the write strobe has priority over the increment request.
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         inc,
    output logic [W-1:0] value
);

    // Purpose: load on write, otherwise step by one on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_val;
        end else if (inc) begin
            value <= value + W'(1);
        end
    end

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> value == $past(wr_val));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && inc) |=> value == $past(value) + W'(1));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inc) |=> $stable(value));

endmodule

// File: rtl/pmu_ctrl_regs.sv
// Module: system registers (run bit, interrupt enables, sticky overflow
// flags, event-select word) and the interrupt request.
// Assumes the select word fits in a data word. A flag set by a wrap wins over
// a same-edge clear.
module pmu_ctrl_regs
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int IDX_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sys_wr,
    input  logic [IDX_W-1:0]          idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_CTR-1:0]        wrap_vec,
    output logic                      run,
    output logic [NUM_CTR-1:0]        ien,
    output logic [NUM_CTR-1:0]        flags,
    output logic [NUM_CTR*CODE_W-1:0] sel_word,
    output logic                      irq
);

    localparam int SEL_W = NUM_CTR * CODE_W;

    logic wr_ctrl, wr_ien, wr_flag, wr_sel;

    // Purpose: decode which system register a write targets
    always_comb begin
        wr_ctrl = sys_wr && (idx == IDX_W'(SYS_CTRL));
        wr_ien  = sys_wr && (idx == IDX_W'(SYS_IEN));
        wr_flag = sys_wr && (idx == IDX_W'(SYS_FLAG));
        wr_sel  = sys_wr && (idx == IDX_W'(SYS_SEL));
    end

    // Purpose: global run bit
    always_ff @(posedge clk) begin
        if (!rst_n)       run <= 1'b0;
        else if (wr_ctrl) run <= wdata[0];
    end

    // Purpose: per-counter interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (wr_ien) ien <= wdata[NUM_CTR-1:0];
    end

    // Purpose: event-select word, parked in every field after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_word <= '1;
        else if (wr_sel) sel_word <= wdata[SEL_W-1:0];
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_flag
        // Purpose: sticky overflow flag with write-one-to-clear
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[g] <= 1'b0;
            else if (wrap_vec[g])            flags[g] <= 1'b1;
            else if (wr_flag && wdata[g])    flags[g] <= 1'b0;
        end

        p_wrap_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_vec[g] |=> flags[g]);

        p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !wrap_vec[g] && wr_flag && wdata[g]) |=> !flags[g]);

        p_flag_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && ien[g]) |-> irq);
    end

    // Purpose: interrupt request from enabled, latched flags
    always_comb begin
        irq = |(flags & ien);
    end

    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(flags & ien) > 0));

endmodule

// File: rtl/perf_monitor_unit.sv
// Module: top of the performance monitor. Four event counters, a cycle
// counter, system registers and the register read mux.
// Assumes a single-cycle write strobe and combinational reads. Counter values
// are zero-extended on read and truncated on write.
module perf_monitor_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32,
    parameter int CYC_W   = 32,
    parameter int IDX_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ev_lines,
    input  logic                 reg_wr,
    input  logic                 reg_grp,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq
);

    logic                      run;
    logic [NUM_CTR-1:0]        ien;
    logic [NUM_CTR-1:0]        flags;
    logic [NUM_CTR*CODE_W-1:0] sel_word;
    logic [NUM_CTR-1:0]        wrap_vec;
    logic [NUM_CTR-1:0]        hit;
    logic [NUM_CTR-1:0]        ctr_wr;
    logic [CTR_W-1:0]          ctr_val [NUM_CTR];
    logic [CYC_W-1:0]          cyc_val;
    logic                      cyc_wr;
    logic                      sys_wr;

    // Purpose: split the write strobe between the two register groups
    always_comb begin
        sys_wr = reg_wr && !reg_grp;
        cyc_wr = sys_wr && (reg_idx == IDX_W'(SYS_CYCLE));
    end

    pmu_ctrl_regs #(
        .NUM_CTR (NUM_CTR),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_wr   (sys_wr),
        .idx      (reg_idx),
        .wdata    (reg_wdata),
        .wrap_vec (wrap_vec),
        .run      (run),
        .ien      (ien),
        .flags    (flags),
        .sel_word (sel_word),
        .irq      (irq)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic [CODE_W-1:0] sel_g;

        // Purpose: slice this counter's select field and decode its write
        always_comb begin
            sel_g     = sel_word[g*CODE_W +: CODE_W];
            ctr_wr[g] = reg_wr && reg_grp && (reg_idx == IDX_W'(g));
        end

        pmu_event_select #(
            .LINES (NUM_LINES)
        ) u_sel (
            .sel      (sel_g),
            .ev_lines (ev_lines),
            .run      (run),
            .hit      (hit[g])
        );

        pmu_counter #(
            .W (CTR_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ctr_wr[g]),
            .wr_val (reg_wdata[CTR_W-1:0]),
            .inc    (hit[g]),
            .value  (ctr_val[g])
        );

        // Purpose: flag a rollover that is not pre-empted by a write
        always_comb begin
            wrap_vec[g] = hit[g] && !ctr_wr[g] && (&ctr_val[g]);
        end

        p_park_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((sel_g == PARK_CODE) && !ctr_wr[g]) |=> $stable(ctr_val[g]));

        p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !ctr_wr[g]) |=> $stable(ctr_val[g]));

        p_write_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ctr_wr[g] && !flags[g]) |=> !flags[g]);
    end

    pmu_counter #(
        .W (CYC_W)
    ) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cyc_wr),
        .wr_val (reg_wdata[CYC_W-1:0]),
        .inc    (run),
        .value  (cyc_val)
    );

    p_cycle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cyc_wr) |=> $stable(cyc_val));

    // Purpose: combinational read mux over both register groups
    always_comb begin
        reg_rdata = '0;
        if (reg_grp) begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (reg_idx == IDX_W'(i)) reg_rdata = DATA_W'(ctr_val[i]);
            end
        end else begin
            case (reg_idx)
                IDX_W'(SYS_CTRL):  reg_rdata = DATA_W'(run);
                IDX_W'(SYS_CYCLE): reg_rdata = DATA_W'(cyc_val);
                IDX_W'(SYS_IEN):   reg_rdata = DATA_W'(ien);
                IDX_W'(SYS_FLAG):  reg_rdata = DATA_W'(flags);
                IDX_W'(SYS_SEL):   reg_rdata = DATA_W'(sel_word);
                default:           reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: tb/perf_monitor_unit_bench.sv
`timescale 1ns/1ps
module perf_monitor_unit_bench;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [255:0] ev_lines = '0;
    logic        reg_wr = 1'b0;
    logic        reg_grp = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    perf_monitor_unit #(.NUM_CTR(4), .CTR_W(CW), .CYC_W(CW), .IDX_W(4)) u_perf_monitor_unit (
        .clk(clk), .rst_n(rst_n), .ev_lines(ev_lines), .reg_wr(reg_wr),
        .reg_grp(reg_grp), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic g, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_grp = g; reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic g, input logic [3:0] i, output logic [31:0] d);
        reg_grp = g; reg_idx = i;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int code, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ev_lines[code] = 1'b1;
            @(negedge clk);
            ev_lines[code] = 1'b0;
        end
    endtask

    function automatic bit countable(input int c);
        return (c >= 0 && c <= 28) || c == 30 || c == 32 || c == 35 ||
               c == 64 || c == 65 || c == 72;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(0, 0, v); check("R1 run", v, 0);
        rd(0, 1, v); check("R1 cycle", v, 0);
        rd(0, 4, v); check("R1 ien", v, 0);
        rd(0, 5, v); check("R1 flags", v, 0);
        rd(0, 8, v); check("R1 select", v, 32'hffffffff);
        for (int i = 0; i < 4; i++) begin
            rd(1, 4'(i), v); check("R1 counter", v, 0);
        end
        check("R1 irq", {31'b0, irq}, 0);

        // R4: parked counters ignore every line while running
        wr(0, 0, 1);
        ev_lines = '1;
        repeat (4) @(negedge clk);
        ev_lines = '0;
        for (int i = 0; i < 4; i++) begin
            rd(1, 4'(i), v); check("R4 parked", v, 0);
        end

        // R6: stopped unit holds counters and cycle counter
        wr(0, 0, 0);
        wr(0, 8, 32'h03020100);
        rd(0, 1, v);
        ev_lines[3:0] = 4'hf;
        repeat (6) @(negedge clk);
        ev_lines = '0;
        rd(0, 1, v2); check("R6 cycle held", v2, v);
        for (int i = 0; i < 4; i++) begin
            rd(1, 4'(i), v); check("R6 counter held", v, 0);
        end

        // R8: counter read/write by index
        for (int i = 0; i < 4; i++) wr(1, 4'(i), 32'(8'h11 * (i + 1)));
        for (int i = 0; i < 4; i++) begin
            rd(1, 4'(i), v); check("R8 readback", v, 32'(8'h11 * (i + 1)));
        end

        // R2, R3: field placement, distinct counts per counter
        wr(0, 8, 32'h48230a01);
        for (int i = 0; i < 4; i++) wr(1, 4'(i), 0);
        wr(0, 0, 1);
        pulse(8'h01, 1); pulse(8'h0a, 2); pulse(8'h23, 3); pulse(8'h48, 4);
        for (int i = 0; i < 4; i++) begin
            rd(1, 4'(i), v); check("R2 R3 field count", v, 32'(i + 1));
        end

        // R5, R4: sweep all codes on counter 0
        for (int c = 0; c < 256; c++) begin
            wr(0, 8, {24'hffffff, 8'(c)});
            wr(1, 0, 0);
            pulse(c, 3);
            rd(1, 0, v);
            check(c == 255 ? "R4 park code" : "R5 code sweep", v, countable(c) ? 3 : 0);
        end

        // R7: cycle counter counts and wraps
        wr(0, 1, 32'h10);
        repeat (5) @(negedge clk);
        rd(0, 1, v); check("R7 cycle step", v, 32'h15);
        wr(0, 1, 32'hfe);
        repeat (3) @(negedge clk);
        rd(0, 1, v); check("R7 cycle wrap", v, 32'h01);

        // R9, R10: overflow flag and interrupt gating
        wr(0, 8, 32'hffff07ff);
        wr(0, 4, 0);
        wr(1, 1, 32'hfe);
        pulse(8'h07, 2);
        rd(1, 1, v); check("R9 wrapped value", v, 0);
        rd(0, 5, v); check("R9 flag set", v, 32'h2);
        check("R10 irq masked", {31'b0, irq}, 0);
        wr(0, 4, 32'h2);
        check("R10 irq raised", {31'b0, irq}, 1);
        wr(0, 5, 32'h1);
        rd(0, 5, v); check("R9 write zero keeps", v, 32'h2);
        wr(0, 5, 32'h2);
        rd(0, 5, v); check("R9 w1c", v, 0);
        check("R10 irq dropped", {31'b0, irq}, 0);

        // R11: write beats same-edge event, no flag
        wr(0, 8, 32'hff0bffff);
        wr(1, 2, 32'hff);
        @(negedge clk);
        ev_lines[8'h0b] = 1'b1;
        reg_grp = 1; reg_idx = 2; reg_wdata = 32'h05; reg_wr = 1'b1;
        @(negedge clk);
        ev_lines = '0; reg_wr = 1'b0;
        rd(1, 2, v); check("R11 write wins", v, 32'h05);
        rd(0, 5, v); check("R11 no flag", v, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule